// File: doc/BRIEF.md
# Interrupt Status, Mask and Priority Bid Unit

This block gathers the interrupt sources of a two-channel serial controller into one 8-bit status word. It also decides whether the controller should raise its shared active-low interrupt line. Transmit and receive readiness are derived from FIFO occupancy figures that the surrounding datapath supplies, together with the level codes that software has programmed. Break-change, counter-ready and pin-change conditions arrive as single-cycle event pulses. Each of them stays latched until its own clear command arrives.

An 8-bit mask selects which pending sources may take part in bidding. Each source has a programmable 3-bit priority. The bid is the highest priority among the sources that are both pending and enabled. The interrupt line is driven low when that bid is strictly above a programmable threshold. Reading the status word is never filtered by the mask. Configuration arrives through a simple write port with a 4-bit address.

Top module: `irq_bid_unit`

## Requirements
- R1: While reset is high at a clock edge, the next state is: status 0x00, mask 0x00, threshold 0, all priorities 0, bid 0 and irq_n high.
- R2: Status bit 0 (channel A) and bit 4 (channel B) report transmitter ready. One clock after the inputs are presented, the bit is 1 exactly when that channel's transmitter is enabled and its free-slot count is at least the selected level. Level code 0 selects 1 slot, code 1 selects 4, code 2 selects 6 and code 3 selects 8. A disabled transmitter gives 0.
- R3: Status bit 1 (channel A) and bit 5 (channel B) report receiver ready. The bit is 1 when the receive fill count is at least the level selected by that channel's 2-bit code, using the same code table as R2.
- R4: A transmit push or a receive pop sampled at clock edge k forces the matching ready bit to 0 after edge k and after edge k+1. From edge k+2 the bit again follows its level condition.
- R5: With level code 3 (8 entries), a pop from a full receive FIFO clears the receiver-ready bit. The bit stays 0 while the fill count is 7. It sets again on the first edge after the count returns to 8 and the two-clock hold-off has passed.
- R6: Status bit 2 (channel A) and bit 6 (channel B) hold break change. The bit sets on a break event and stays set until a break acknowledge. An event and an acknowledge in the same cycle leave the bit set.
- R7: Status bit 3 is counter ready: it is set by a counter event and cleared by a counter stop. Status bit 7 is pin change: it is set by a pin-change event and cleared by a pin-change acknowledge. For both bits, an event wins over a clear in the same cycle.
- R8: Writing the mask never changes the status output.
- R9: One clock after the status, mask or priorities change, bid equals the largest priority among the bits set in both status and mask. With no such bit, bid is 0.
- R10: irq_n is registered together with bid. It is low exactly when that bid is strictly greater than the threshold, so a bid equal to the threshold leaves irq_n high.
- R11: The configuration address map is as follows. Address 0x0 writes the mask. Address 0x1 writes the threshold from wdata[2:0]. Addresses 0x8 to 0xF write the priority of source (addr-8) from wdata[2:0]. Writes to addresses 0x2 to 0x7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| tx_en | input | 2 | Transmitter enable per channel (bit 0 = A) |
| tx_free | input | 8 | Free transmit slots, 4 bits per channel |
| tx_lvl | input | 4 | Transmit level code, 2 bits per channel |
| tx_push | input | 2 | Transmit FIFO write strobe per channel |
| rx_fill | input | 8 | Receive fill count, 4 bits per channel |
| rx_lvl | input | 4 | Receive level code, 2 bits per channel |
| rx_pop | input | 2 | Receive FIFO read strobe per channel |
| brk_evt | input | 2 | Break begin/end event per channel |
| brk_ack | input | 2 | Break-change clear command per channel |
| ct_evt | input | 1 | Counter terminal event |
| ct_stop | input | 1 | Counter stop command (clears bit 3) |
| pin_chg_evt | input | 1 | Input pin change event |
| pin_chg_ack | input | 1 | Pin change acknowledge (clears bit 7) |
| isr | output | 8 | Interrupt status word, never masked |
| bid | output | 3 | Current winning priority |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest state to reach is a ready bit that is still inside its two-clock hold-off when a second strobe arrives, or when the level condition flips, or when the level code changes. In those cases the re-set edge moves, and a plain level comparison would predict the wrong cycle. The random stimulus drives push and pop strobes often and changes counts on every cycle, so back-to-back and overlapping strobes occur many times. A per-cycle reference model tracks the hold-off for each source. The directed sequences set up the full-FIFO pop case and the case where the bid equals the threshold, which random configuration writes seldom produce.

// File: rtl/irq_bid_pkg.sv
`timescale 1ns/1ps
package irq_bid_pkg;
  localparam int unsigned NUM_SRC   = 8;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned CH_STRIDE = 4;
  localparam int unsigned OFS_TX    = 0;
  localparam int unsigned OFS_RX    = 1;
  localparam int unsigned OFS_BRK   = 2;
  localparam int unsigned SRC_CNT   = 3;
  localparam int unsigned SRC_PIN   = 7;

  localparam logic [3:0] CFG_MASK = 4'h0;
  localparam logic [3:0] CFG_THR  = 4'h1;

  typedef enum logic [1:0] {
    LVL_ONE  = 2'd0,
    LVL_HALF = 2'd1,
    LVL_3Q   = 2'd2,
    LVL_FULL = 2'd3
  } lvl_code_e;

  // Entry count selected by a 2-bit level code for a FIFO of the given depth
  function automatic int unsigned level_of(input logic [1:0] code, input int unsigned depth);
    case (lvl_code_e'(code))
      LVL_ONE:  return 1;
      LVL_HALF: return depth / 2;
      LVL_3Q:   return (depth * 3) / 4;
      default:  return depth;
    endcase
  endfunction
endpackage

// File: rtl/irq_ready_track.sv
`timescale 1ns/1ps
module irq_ready_track
  import irq_bid_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned REARM = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       lvl_code,
  input  logic             strobe,
  output logic             flag
);
  localparam int unsigned HOLD_W = (REARM > 1) ? $clog2(REARM) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(REARM - 1);

  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  need;
  logic              cond;
  logic              flag_q;

  always_comb begin
    need = CNT_W'(level_of(lvl_code, DEPTH));
    cond = enable && (count >= need);
  end

  // FIFO access drops the flag and holds it off for REARM edges in total
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      hold_q <= '0;
    end else if (strobe) begin
      flag_q <= 1'b0;
      hold_q <= HOLD_LOAD;
    end else if (hold_q != '0) begin
      flag_q <= 1'b0;
      hold_q <= hold_q - 1'b1;
    end else begin
      flag_q <= cond;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_sticky_flag.sv
`timescale 1ns/1ps
module irq_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  // A set in the same cycle as a clear wins so no event is lost
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_bid_arb.sv
`timescale 1ns/1ps
module irq_bid_arb #(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned PRIO_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]      thr,
  output logic [PRIO_W-1:0]      bid,
  output logic                   irq_n
);
  logic [PRIO_W-1:0] best;
  logic [PRIO_W-1:0] bid_q;
  logic              irq_n_q;

  always_comb begin
    best = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (pend[s] && (prio_flat[s*PRIO_W +: PRIO_W] > best))
        best = prio_flat[s*PRIO_W +: PRIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bid_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      bid_q   <= best;
      irq_n_q <= !(best > thr);
    end
  end

  assign bid   = bid_q;
  assign irq_n = irq_n_q;
endmodule

// File: rtl/irq_bid_unit.sv
`timescale 1ns/1ps
module irq_bid_unit
  import irq_bid_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned PRIO_W     = 3,
  parameter int unsigned REARM_CYC  = 2,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [3:0]              cfg_addr,
  input  logic [7:0]              cfg_wdata,
  input  logic [NUM_CH-1:0]       tx_en,
  input  logic [NUM_CH*CNT_W-1:0] tx_free,
  input  logic [NUM_CH*2-1:0]     tx_lvl,
  input  logic [NUM_CH-1:0]       tx_push,
  input  logic [NUM_CH*CNT_W-1:0] rx_fill,
  input  logic [NUM_CH*2-1:0]     rx_lvl,
  input  logic [NUM_CH-1:0]       rx_pop,
  input  logic [NUM_CH-1:0]       brk_evt,
  input  logic [NUM_CH-1:0]       brk_ack,
  input  logic                    ct_evt,
  input  logic                    ct_stop,
  input  logic                    pin_chg_evt,
  input  logic                    pin_chg_ack,
  output logic [NUM_SRC-1:0]      isr,
  output logic [PRIO_W-1:0]       bid,
  output logic                    irq_n
);
  logic [NUM_SRC-1:0]        mask_q;
  logic [PRIO_W-1:0]         thr_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]        isr_w;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      thr_q  <= '0;
      prio_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == CFG_MASK) mask_q <= cfg_wdata[NUM_SRC-1:0];
      if (cfg_addr == CFG_THR)  thr_q  <= cfg_wdata[PRIO_W-1:0];
      for (int s = 0; s < NUM_SRC; s++) begin
        if (cfg_addr == {1'b1, 3'(s)})
          prio_q[s*PRIO_W +: PRIO_W] <= cfg_wdata[PRIO_W-1:0];
      end
    end
  end

  // Per-channel sources: transmit ready, receive ready, break change
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_ready_track #(
      .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .REARM(REARM_CYC)
    ) u_tx_rdy (
      .clk      (clk),
      .rst      (rst),
      .enable   (tx_en[c]),
      .count    (tx_free[c*CNT_W +: CNT_W]),
      .lvl_code (tx_lvl[c*2 +: 2]),
      .strobe   (tx_push[c]),
      .flag     (isr_w[c*CH_STRIDE + OFS_TX])
    );

    irq_ready_track #(
      .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .REARM(REARM_CYC)
    ) u_rx_rdy (
      .clk      (clk),
      .rst      (rst),
      .enable   (1'b1),
      .count    (rx_fill[c*CNT_W +: CNT_W]),
      .lvl_code (rx_lvl[c*2 +: 2]),
      .strobe   (rx_pop[c]),
      .flag     (isr_w[c*CH_STRIDE + OFS_RX])
    );

    irq_sticky_flag u_brk (
      .clk  (clk),
      .rst  (rst),
      .set  (brk_evt[c]),
      .clr  (brk_ack[c]),
      .flag (isr_w[c*CH_STRIDE + OFS_BRK])
    );
  end

  // Shared sources
  irq_sticky_flag u_ct (
    .clk  (clk),
    .rst  (rst),
    .set  (ct_evt),
    .clr  (ct_stop),
    .flag (isr_w[SRC_CNT])
  );

  irq_sticky_flag u_pin (
    .clk  (clk),
    .rst  (rst),
    .set  (pin_chg_evt),
    .clr  (pin_chg_ack),
    .flag (isr_w[SRC_PIN])
  );

  irq_bid_arb #(
    .NSRC(NUM_SRC), .PRIO_W(PRIO_W)
  ) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (isr_w & mask_q),
    .prio_flat (prio_q),
    .thr       (thr_q),
    .bid       (bid),
    .irq_n     (irq_n)
  );

  assign isr = isr_w;
endmodule

// File: rtl/irq_bid_unit_chk.sv
`timescale 1ns/1ps
module irq_bid_unit_chk #(
  parameter int unsigned PRIO_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        tx_en,
  input logic [1:0]        tx_push,
  input logic [1:0]        rx_pop,
  input logic [1:0]        brk_evt,
  input logic [1:0]        brk_ack,
  input logic [7:0]        isr,
  input logic [7:0]        mask_q,
  input logic [PRIO_W-1:0] bid,
  input logic              irq_n
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (isr == 8'h00 && irq_n && bid == '0));

  a_r2_tx_disabled: assert property (@(posedge clk) disable iff (rst)
    !tx_en[1] |=> !isr[4]);

  a_r4_push_drop: assert property (@(posedge clk) disable iff (rst)
    tx_push[0] |=> !isr[0]);

  a_r4_push_hold: assert property (@(posedge clk) disable iff (rst)
    tx_push[0] ##1 1'b1 |=> !isr[0]);

  a_r4_pop_drop: assert property (@(posedge clk) disable iff (rst)
    rx_pop[1] |=> !isr[5]);

  a_r6_brk_set: assert property (@(posedge clk) disable iff (rst)
    brk_evt[0] |=> isr[2]);

  a_r6_brk_hold: assert property (@(posedge clk) disable iff (rst)
    (isr[6] && !brk_ack[1]) |=> isr[6]);

  a_r9_no_pending: assert property (@(posedge clk) disable iff (rst)
    ((isr & mask_q) == 8'h00) |=> (bid == '0));

  a_r10_low_needs_bid: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (bid != '0));
endmodule

bind irq_bid_unit irq_bid_unit_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_en   (tx_en),
  .tx_push (tx_push),
  .rx_pop  (rx_pop),
  .brk_evt (brk_evt),
  .brk_ack (brk_ack),
  .isr     (isr),
  .mask_q  (mask_q),
  .bid     (bid),
  .irq_n   (irq_n)
);

// File: tb/test_irq_bid_unit.sv
`timescale 1ns/1ps
module test_irq_bid_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_wr;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [1:0] tx_en, tx_push, rx_pop, brk_evt, brk_ack;
  logic [7:0] tx_free, rx_fill;
  logic [3:0] tx_lvl, rx_lvl;
  logic       ct_evt, ct_stop, pin_chg_evt, pin_chg_ack;
  logic [7:0] isr;
  logic [2:0] bid;
  logic       irq_n;

  irq_bid_unit i_irq_bid_unit (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_en(tx_en), .tx_free(tx_free), .tx_lvl(tx_lvl), .tx_push(tx_push),
    .rx_fill(rx_fill), .rx_lvl(rx_lvl), .rx_pop(rx_pop),
    .brk_evt(brk_evt), .brk_ack(brk_ack), .ct_evt(ct_evt), .ct_stop(ct_stop),
    .pin_chg_evt(pin_chg_evt), .pin_chg_ack(pin_chg_ack),
    .isr(isr), .bid(bid), .irq_n(irq_n)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Reference model built from the requirements
  logic [7:0] m_isr, m_mask;
  logic [2:0] m_thr, m_bid;
  logic       m_irqn;
  logic [2:0] m_prio [8];
  int         m_hold [8];

  function automatic int lvl(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic ready_step(input int i, input logic stb, input logic cond, inout logic [7:0] v);
    if (stb) begin
      v[i] = 1'b0; m_hold[i] = 1;
    end else if (m_hold[i] > 0) begin
      v[i] = 1'b0; m_hold[i] = m_hold[i] - 1;
    end else begin
      v[i] = cond;
    end
  endtask

  always @(posedge clk) begin : model
    logic [7:0] pend, nx;
    logic [2:0] best;
    if (rst) begin
      m_isr <= '0; m_mask <= '0; m_thr <= '0; m_bid <= '0; m_irqn <= 1'b1;
      for (int s = 0; s < 8; s++) begin m_prio[s] <= '0; m_hold[s] = 0; end
    end else begin
      pend = m_isr & m_mask;
      best = '0;
      for (int s = 0; s < 8; s++) if (pend[s] && m_prio[s] > best) best = m_prio[s];
      m_bid  <= best;
      m_irqn <= !(best > m_thr);
      nx = m_isr;
      for (int c = 0; c < 2; c++) begin
        ready_step(4*c,   tx_push[c], tx_en[c] && (int'(tx_free[c*4 +: 4]) >= lvl(tx_lvl[c*2 +: 2])), nx);
        ready_step(4*c+1, rx_pop[c],  int'(rx_fill[c*4 +: 4]) >= lvl(rx_lvl[c*2 +: 2]), nx);
        if (brk_evt[c]) nx[4*c+2] = 1'b1; else if (brk_ack[c]) nx[4*c+2] = 1'b0;
      end
      if (ct_evt) nx[3] = 1'b1; else if (ct_stop) nx[3] = 1'b0;
      if (pin_chg_evt) nx[7] = 1'b1; else if (pin_chg_ack) nx[7] = 1'b0;
      m_isr <= nx;
      if (cfg_wr) begin
        if (cfg_addr == 4'h0) m_mask <= cfg_wdata;
        if (cfg_addr == 4'h1) m_thr <= cfg_wdata[2:0];
        if (cfg_addr[3]) m_prio[cfg_addr[2:0]] <= cfg_wdata[2:0];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic compare();
    chk("R2 tx ready vs model", {isr[4], isr[0]}, {m_isr[4], m_isr[0]});
    chk("R3 rx ready vs model", {isr[5], isr[1]}, {m_isr[5], m_isr[1]});
    chk("R6/R7 latched bits vs model", {isr[7], isr[6], isr[3], isr[2]},
        {m_isr[7], m_isr[6], m_isr[3], m_isr[2]});
    chk("R9 bid vs model", bid, m_bid);
    chk("R10 irq_n vs model", irq_n, m_irqn);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] saved;
    void'($urandom(32'h1C0FFEE));
    rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tx_en = '0; tx_push = '0; rx_pop = '0; brk_evt = '0; brk_ack = '0;
    tx_free = '0; rx_fill = '0; tx_lvl = '0; rx_lvl = '0;
    ct_evt = 0; ct_stop = 0; pin_chg_evt = 0; pin_chg_ack = 0;
    tx_en = 2'b11; tx_free = 8'h88; rx_fill = 8'h88;   // conditions true but reset wins
    @(negedge clk);
    tick(); tick();
    chk("R1 reset isr", isr, 8'h00);
    chk("R1 reset bid", bid, 3'd0);
    chk("R1 reset irq_n", irq_n, 1'b1);
    tx_en = '0; tx_free = '0; rx_fill = '0;
    rst = 1'b0;
    tick();

    // R2: level code 2 selects 6 free slots
    tx_en = 2'b11; tx_lvl = 4'b1010; tx_free = {4'd5, 4'd6};
    tick();
    chk("R2 ch A free 6 at level 6", isr[0], 1'b1);
    chk("R2 ch B free 5 at level 6", isr[4], 1'b0);
    tx_en = 2'b10;
    tick();
    chk("R2 disabled transmitter", isr[0], 1'b0);

    // R3: level code 1 selects 4 entries
    rx_lvl = 4'b0101; rx_fill = {4'd4, 4'd3};
    tick();
    chk("R3 ch A fill 3 at level 4", isr[1], 1'b0);
    chk("R3 ch B fill 4 at level 4", isr[5], 1'b1);

    // R4: push drop and two-clock re-arm
    tx_en = 2'b11; tx_lvl = 4'b0000; tx_free = 8'h88;
    tick();
    chk("R4 ready before push", isr[0], 1'b1);
    tx_push = 2'b01;
    tick();
    chk("R4 cleared after push edge", isr[0], 1'b0);
    tx_push = 2'b00;
    tick();
    chk("R4 still held second edge", isr[0], 1'b0);
    tick();
    chk("R4 re-armed third edge", isr[0], 1'b1);

    // R5: full-level pop with a byte waiting behind the FIFO
    rx_lvl = 4'b0111; rx_fill = {4'd4, 4'd8};
    tick(); tick();
    chk("R5 ready at 8 of 8", isr[1], 1'b1);
    rx_pop = 2'b01;
    tick();
    rx_pop = 2'b00; rx_fill = {4'd4, 4'd7};
    tick(); tick(); tick();
    chk("R5 stays clear at 7", isr[1], 1'b0);
    rx_fill = {4'd4, 4'd8};
    tick();
    chk("R5 sets when byte refills", isr[1], 1'b1);

    // R6: break change latched until acknowledge, event wins
    brk_evt = 2'b01;
    tick();
    brk_evt = 2'b00;
    tick(); tick();
    chk("R6 break latched", isr[2], 1'b1);
    brk_evt = 2'b01; brk_ack = 2'b01;
    tick();
    chk("R6 event beats acknowledge", isr[2], 1'b1);
    brk_evt = 2'b00;
    tick();
    chk("R6 acknowledge clears", isr[2], 1'b0);
    brk_ack = 2'b00;

    // R7: counter ready and pin change
    ct_evt = 1; pin_chg_evt = 1;
    tick();
    ct_evt = 0; pin_chg_evt = 0;
    tick();
    chk("R7 counter bit set", isr[3], 1'b1);
    chk("R7 pin change bit set", isr[7], 1'b1);
    ct_stop = 1;
    tick();
    ct_stop = 0;
    chk("R7 counter stop clears", isr[3], 1'b0);
    chk("R7 pin bit unaffected by stop", isr[7], 1'b1);
    pin_chg_ack = 1;
    tick();
    pin_chg_ack = 0;
    chk("R7 pin ack clears", isr[7], 1'b0);

    // R9/R10/R11/R8: bidding
    tx_en = 2'b11; tx_lvl = 4'b0000; tx_free = 8'h88; rx_fill = 8'h00;
    tick(); tick();
    cfg_write(4'h8, 8'd5);
    cfg_write(4'hC, 8'd3);
    cfg_write(4'h1, 8'd4);
    cfg_write(4'h0, 8'h11);
    tick();
    chk("R9 bid picks highest", bid, 3'd5);
    chk("R10 bid 5 above 4", irq_n, 1'b0);
    saved = isr;
    cfg_write(4'h1, 8'd5);
    tick();
    chk("R10 equal does not assert", irq_n, 1'b1);
    cfg_write(4'h2, 8'hFF);
    tick();
    chk("R11 unused address ignored", bid, 3'd5);
    chk("R11 unused address leaves irq", irq_n, 1'b1);
    cfg_write(4'h0, 8'h10);
    tick();
    chk("R11 mask selects source 4", bid, 3'd3);
    chk("R8 mask leaves status", isr, saved);
    cfg_write(4'h0, 8'h00);
    tick();
    chk("R9 nothing enabled", bid, 3'd0);
    chk("R8 zero mask leaves status", isr, saved);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      tx_en   = {($urandom_range(0, 9) != 0), ($urandom_range(0, 9) != 0)};
      tx_free = {4'($urandom_range(0, 8)), 4'($urandom_range(0, 8))};
      rx_fill = {4'($urandom_range(0, 8)), 4'($urandom_range(0, 8))};
      tx_push = {($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0)};
      rx_pop  = {($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0)};
      if ($urandom_range(0, 19) == 0) tx_lvl = 4'($urandom);
      if ($urandom_range(0, 19) == 0) rx_lvl = 4'($urandom);
      brk_evt = {($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)};
      brk_ack = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
      ct_evt = ($urandom_range(0, 15) == 0); ct_stop = ($urandom_range(0, 7) == 0);
      pin_chg_evt = ($urandom_range(0, 15) == 0); pin_chg_ack = ($urandom_range(0, 7) == 0);
      cfg_wr = ($urandom_range(0, 9) == 0);
      cfg_addr = 4'($urandom); cfg_wdata = 8'($urandom);
      tick();
    end
    cfg_wr = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule